// File: doc/BRIEF.md
# Fast-Page-Mode DRAM Controller

This block sits between a simple request port and one asynchronous DRAM with a multiplexed address bus. A client offers one access at a time: a write flag, a row, a column and, for writes, a data word. The block turns each access into a timed sequence on the row strobe, the column strobe, the write enable and the output enable, with every limit set as a number of clock cycles.

After reset the block waits with both strobes idle for the power-up pause. It then runs a fixed number of refresh cycles in which the column strobe falls before the row strobe, so that the DRAM uses its own row counter. Only after these wake-up refreshes does it accept work. From then on a timer asks for a refresh at a fixed interval. The refresh takes over at the next point where an access has finished, and it closes any open row first.

The block leaves a row open while the next request names the same row and arrives before the current column cycle ends. It then toggles only the column strobe. A change of row, a late request or a pending refresh closes the row with a full precharge. Writes drive the write enable ahead of the column strobe, so the DRAM output stays off. Read data is sampled a fixed number of cycles after the column strobe falls.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: From reset, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are high, `dram_dq_oe` is low and `req_ready` is low. The strobes stay high until at least T_INIT cycles after reset is released.
- R2: Before the first row opened for an access, the block completes at least N_WAKE refresh cycles in which the column strobe leads the row strobe. `req_ready` stays low until they are done.
- R3: In a refresh cycle, `dram_cas_n` is already low in the cycle before `dram_ras_n` falls. It stays low for at least T_CHR cycles after that fall, and `dram_ras_n` stays low for at least T_RAS cycles.
- R4: Each fall of `dram_ras_n` follows at least T_RP cycles with `dram_ras_n` high.
- R5: For an access, the row address is on `dram_addr` when `dram_ras_n` falls. The column address is on it when `dram_cas_n` falls, which is at least T_RCD cycles later.
- R6: Requests accepted back to back for the same row keep `dram_ras_n` low. Between column accesses `dram_cas_n` is high for at least T_CP cycles and low for at least T_CAS cycles, and from one fall to the next at least T_PC cycles pass.
- R7: A request for a different row, or no request by the end of the column cycle, raises `dram_ras_n`, so the next access opens a new row.
- R8: For a write, `dram_we_n` is low for at least T_WCS cycles before `dram_cas_n` falls, with `dram_oe_n` high and the write data driven (`dram_dq_oe` high). `dram_we_n` does not change while `dram_cas_n` is low.
- R9: `dram_dq_oe` is never high while `dram_oe_n` is low. It rises only after `dram_oe_n` has been high for at least T_OED cycles.
- R10: For a read, `rd_valid` pulses for one cycle with `rd_data` equal to `dram_dq_in` as sampled T_CAPT cycles after `dram_cas_n` fell. `dram_we_n` stays high during the read.
- R11: Once the wake-up is complete, refresh cycles start at intervals of no more than T_REF_INT cycles plus the length of one access, whether the block is idle or streaming a page.
- R12: A request is taken in a cycle where `req_valid` and `req_ready` are both high. Every accepted read returns exactly one `rd_valid`, in the order of acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DATA_W | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed address |
| dram_dq_out | output | DATA_W | Data driven to the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DATA_W | Data from the DRAM |

## Verification
A wrong state in the sequencer shows at the strobes within one access. A short precharge, an early column strobe or a refresh taken in the wrong order breaks an interval that the bench times on every edge, on the very next strobe edge. A wrong open row or a wrong capture cycle appears as a bad word on the first read of that location, because the DRAM model drives inverted data until its access time has passed. A stuck refresh timer shows as an interval overrun, at the latest one refresh period later.

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
  parameter int ROW_W     = 9,
  parameter int COL_W     = 9,
  parameter int DATA_W    = 4,
  parameter int T_INIT    = 20000,
  parameter int N_WAKE    = 8,
  parameter int T_RP      = 4,
  parameter int T_RAS     = 6,
  parameter int T_RCD     = 2,
  parameter int T_CAS     = 2,
  parameter int T_CP      = 1,
  parameter int T_PC      = 4,
  parameter int T_WCS     = 1,
  parameter int T_CHR     = 1,
  parameter int T_CAPT    = 2,
  parameter int T_OED     = 2,
  parameter int T_REF_INT = 1560
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);
  localparam int ADDR_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int T_RREF  = (T_RAS > T_CHR) ? T_RAS : T_CHR;
  localparam int T_CPE   = (T_PC - T_CAS - T_WCS > T_CP) ? T_PC - T_CAS - T_WCS : T_CP;
  localparam int CNT_MAX = T_INIT + T_RREF + T_RP + T_RCD + T_WCS + T_CAS + T_CPE;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int TMR_W   = $clog2(T_REF_INT + 1);
  localparam int WK_W    = $clog2(N_WAKE + 1);
  localparam int GAP_W   = $clog2(T_OED + 1);

  typedef enum logic [3:0] {
    S_PAUSE, S_RCAS, S_RRAS, S_RPRE, S_IDLE, S_ACT, S_SETUP, S_CASL, S_CASH, S_PRE
  } st_t;

  st_t st, st_n;
  logic [CNT_W-1:0]  cnt;
  logic [TMR_W-1:0]  tmr;
  logic [WK_W-1:0]   wake;
  logic [GAP_W-1:0]  gap;
  logic              ref_pend, init_done;
  logic              wr_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] wdata_q;
  logic              ras_n_q, cas_n_q, we_n_q, oe_n_q, dq_oe_q, rd_valid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] rd_data_q;
  logic              accept, wr_n, gap_ok;

  function automatic logic at(input int n);
    return int'(cnt) >= n - 1;
  endfunction

  assign req_ready = init_done && !ref_pend &&
                     ((st == S_IDLE) || (st == S_CASH && at(T_CPE) && req_row == row_q));
  assign accept = req_valid && req_ready;
  assign wr_n   = accept ? req_write : wr_q;
  assign gap_ok = oe_n_q && (int'(gap) >= T_OED - 1);

  always_comb begin
    st_n = st;
    case (st)
      S_PAUSE: if (at(T_INIT)) st_n = S_RCAS;
      S_RCAS:  st_n = S_RRAS;
      S_RRAS:  if (at(T_RREF)) st_n = S_RPRE;
      S_RPRE:  if (at(T_RP))
                 st_n = (init_done || int'(wake) == N_WAKE - 1) ? S_IDLE : S_RCAS;
      S_IDLE:  if (ref_pend) st_n = S_RCAS;
               else if (accept) st_n = S_ACT;
      S_ACT:   if (at(T_RCD)) st_n = S_SETUP;
      S_SETUP: if (at(T_WCS) && (!wr_q || dq_oe_q)) st_n = S_CASL;
      S_CASL:  if (at(T_CAS)) st_n = S_CASH;
      S_CASH:  if (at(T_CPE)) st_n = accept ? S_SETUP : S_PRE;
      S_PRE:   if (at(T_RP)) st_n = S_IDLE;
      default: st_n = S_PAUSE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_PAUSE;
      cnt <= '0;
      tmr <= '0;
      wake <= '0;
      gap <= '0;
      ref_pend <= 1'b0;
      init_done <= 1'b0;
      wr_q <= 1'b0;
      row_q <= '0;
      col_q <= '0;
      wdata_q <= '0;
      ras_n_q <= 1'b1;
      cas_n_q <= 1'b1;
      we_n_q <= 1'b1;
      oe_n_q <= 1'b1;
      dq_oe_q <= 1'b0;
      addr_q <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q <= '0;
    end else begin
      st <= st_n;
      if (st_n != st) cnt <= '0;
      else if (cnt != '1) cnt <= cnt + 1'b1;

      if (st == S_RPRE && at(T_RP) && !init_done) begin
        if (int'(wake) == N_WAKE - 1) init_done <= 1'b1;
        else wake <= wake + 1'b1;
      end

      if (st_n == S_RCAS) ref_pend <= 1'b0;
      if (!init_done) tmr <= '0;
      else if (int'(tmr) == T_REF_INT - 1) begin
        tmr <= '0;
        ref_pend <= 1'b1;
      end else tmr <= tmr + 1'b1;

      if (!oe_n_q) gap <= '0;
      else if (int'(gap) < T_OED) gap <= gap + 1'b1;

      if (accept) begin
        wr_q <= req_write;
        row_q <= req_row;
        col_q <= req_col;
        wdata_q <= req_wdata;
      end

      ras_n_q <= !(st_n inside {S_RRAS, S_ACT, S_SETUP, S_CASL, S_CASH});
      cas_n_q <= !(st_n inside {S_RCAS, S_RRAS, S_CASL});
      we_n_q  <= !((st_n inside {S_SETUP, S_CASL}) && wr_n);
      oe_n_q  <= !(st_n == S_CASL && !wr_q);
      dq_oe_q <= (st_n inside {S_SETUP, S_CASL}) && wr_n && gap_ok;
      if (st_n == S_ACT)
        addr_q <= ADDR_W'(accept ? req_row : row_q);
      else if (st_n == S_SETUP)
        addr_q <= ADDR_W'(accept ? req_col : col_q);

      rd_valid_q <= (st == S_CASL) && !wr_q && (int'(cnt) == T_CAPT - 1);
      if ((st == S_CASL) && !wr_q && (int'(cnt) == T_CAPT - 1)) rd_data_q <= dram_dq_in;
    end
  end

  assign rd_valid    = rd_valid_q;
  assign rd_data     = rd_data_q;
  assign dram_ras_n  = ras_n_q;
  assign dram_cas_n  = cas_n_q;
  assign dram_we_n   = we_n_q;
  assign dram_oe_n   = oe_n_q;
  assign dram_addr   = addr_q;
  assign dram_dq_out = wdata_q;
  assign dram_dq_oe  = dq_oe_q;

  localparam int SAT_V = T_RP + T_RCD + 1;
  localparam int SAT_W = $clog2(SAT_V + 1);
  logic [SAT_W-1:0] ras_hi, ras_lo;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_hi <= SAT_W'(SAT_V);
      ras_lo <= '0;
    end else begin
      ras_hi <= !ras_n_q ? '0 : (int'(ras_hi) == SAT_V ? ras_hi : ras_hi + 1'b1);
      ras_lo <=  ras_n_q ? '0 : (int'(ras_lo) == SAT_V ? ras_lo : ras_lo + 1'b1);
    end
  end

  p_pause_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PAUSE) |-> (ras_n_q && cas_n_q));
  p_cbr_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n_q) && !cas_n_q) |-> !$past(cas_n_q));
  p_precharge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_q) |-> (int'(ras_hi) >= T_RP));
  p_row_to_col_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n_q) && !ras_n_q) |-> (int'(ras_lo) >= T_RCD));
  p_we_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n_q && $past(!cas_n_q)) |-> $stable(we_n_q));
  p_bus_clash_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(dq_oe_q && !oe_n_q));
  p_rd_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_q |=> !rd_valid_q);
endmodule

// File: tb/test_fpm_dram_ctrl.sv
module test_fpm_dram_ctrl;
  localparam int ROW_W = 9, COL_W = 9, DATA_W = 4, ADDR_W = 9;
  localparam int T_INIT = 20000, N_WAKE = 8, T_RP = 4, T_RAS = 6, T_RCD = 2;
  localparam int T_CAS = 2, T_CP = 1, T_PC = 4, T_WCS = 1, T_CHR = 1;
  localparam int T_CAPT = 2, T_OED = 2, T_REF_INT = 1560, SLACK = 40;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [DATA_W-1:0] req_wdata = '0, dram_dq_in = '0;
  logic req_ready, rd_valid, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [DATA_W-1:0] rd_data, dq_out;
  logic [ADDR_W-1:0] addr;

  always #5 clk = ~clk;

  fpm_dram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_INIT(T_INIT),
    .N_WAKE(N_WAKE), .T_RP(T_RP), .T_RAS(T_RAS), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .T_CP(T_CP), .T_PC(T_PC), .T_WCS(T_WCS), .T_CHR(T_CHR), .T_CAPT(T_CAPT),
    .T_OED(T_OED), .T_REF_INT(T_REF_INT)) i_fpm_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_ras_n(ras_n), .dram_cas_n(cas_n),
    .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_addr(addr), .dram_dq_out(dq_out),
    .dram_dq_oe(dq_oe), .dram_dq_in(dram_dq_in));

  int checks = 0, errors = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] dflt(input int k);
    return k[3:0] ^ k[11:8] ^ 4'h9;
  endfunction

  logic [3:0] dram_mem [int];
  logic [3:0] ref_mem [int];
  logic [3:0] expq [$];
  int reads_acc = 0, reads_ret = 0;

  // DRAM model and strobe timing monitor, sampled on the falling clock edge
  bit p_ras = 1, p_cas = 1, p_we = 1, p_oe = 1, p_dq = 0;
  int cyc = 0, ras_hi_c = 1000, ras_lo_c = 0, cas_hi_c = 1000, cas_lo_c = 0;
  int since_fall = 1000, we_lo_c = 0, oe_hi_c = 1000, lowcnt = 0;
  int cbr_cnt = 0, last_cbr = 0, nras = 0;
  bit cbr_flag = 0, first_cas = 0, normal_seen = 0, active_seen = 0;
  int row_l = 0, col_l = 0;

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      bit fr, rr, fc, rc;
      int key;
      cyc++;
      fr = p_ras && !ras_n; rr = !p_ras && ras_n;
      fc = p_cas && !cas_n; rc = !p_cas && cas_n;
      if (!active_seen && (!ras_n || !cas_n)) begin
        active_seen = 1;
        chk(cyc >= T_INIT, "R1 pause length", cyc, T_INIT);
      end
      if (fr) begin
        chk(ras_hi_c >= T_RP, "R4 precharge", ras_hi_c, T_RP);
        if (!cas_n) begin
          chk(!p_cas, "R3 column strobe leads", p_cas, 0);
          cbr_flag = 1;
          cbr_cnt++;
          if (cbr_cnt > N_WAKE)
            chk(cyc - last_cbr <= T_REF_INT + SLACK, "R11 refresh interval", cyc - last_cbr, T_REF_INT + SLACK);
          last_cbr = cyc;
        end else begin
          cbr_flag = 0;
          if (!normal_seen) chk(cbr_cnt >= N_WAKE, "R2 wake refreshes", cbr_cnt, N_WAKE);
          normal_seen = 1;
          first_cas = 1;
          row_l = int'(addr);
          nras++;
        end
      end
      if (rc && cbr_flag) chk(ras_lo_c >= T_CHR, "R3 column hold", ras_lo_c, T_CHR);
      if (rr && cbr_flag) chk(ras_lo_c >= T_RAS, "R3 row low width", ras_lo_c, T_RAS);
      if (fc && !ras_n && !p_ras) begin
        if (first_cas) chk(ras_lo_c >= T_RCD, "R5 row to column", ras_lo_c, T_RCD);
        else begin
          chk(since_fall >= T_PC, "R6 page cycle", since_fall, T_PC);
          chk(cas_hi_c >= T_CP, "R6 column precharge", cas_hi_c, T_CP);
        end
        first_cas = 0;
        col_l = int'(addr);
        if (!we_n) begin
          chk(we_lo_c >= T_WCS && oe_n && dq_oe, "R8 early write", we_lo_c, T_WCS);
          dram_mem[(row_l << COL_W) | col_l] = dq_out;
        end
      end
      if (rc && !cbr_flag) chk(cas_lo_c >= T_CAS, "R6 column low width", cas_lo_c, T_CAS);
      if (!cas_n && !p_cas && !ras_n) chk(we_n == p_we, "R8 write enable steady", we_n, p_we);
      if (!cas_n && !ras_n && oe_n == 0) chk(we_n, "R10 no write during read", we_n, 1);
      if (dq_oe) chk(oe_n, "R9 bus clash", oe_n, 1);
      if (dq_oe && !p_dq) chk(oe_hi_c >= T_OED, "R9 turnaround", oe_hi_c, T_OED);
      if (rd_valid) begin
        reads_ret++;
        if (expq.size() == 0) chk(0, "R12 extra read data", reads_ret, reads_acc);
        else begin
          logic [3:0] e;
          e = expq.pop_front();
          chk(rd_data == e, "R10 read data", rd_data, e);
        end
      end
      since_fall = fc ? 1 : since_fall + 1;
      ras_hi_c = ras_n ? ras_hi_c + 1 : 0;
      ras_lo_c = !ras_n ? ras_lo_c + 1 : 0;
      cas_hi_c = cas_n ? cas_hi_c + 1 : 0;
      cas_lo_c = !cas_n ? cas_lo_c + 1 : 0;
      we_lo_c  = !we_n ? we_lo_c + 1 : 0;
      oe_hi_c  = oe_n ? oe_hi_c + 1 : 0;
      if (!cas_n && !ras_n) lowcnt = p_cas ? 1 : lowcnt + 1;
      else lowcnt = 0;
      key = (row_l << COL_W) | col_l;
      if (lowcnt > 0 && we_n) begin
        logic [3:0] v;
        v = dram_mem.exists(key) ? dram_mem[key] : dflt(key);
        dram_dq_in = (lowcnt >= T_CAPT) ? v : ~v;
      end else dram_dq_in = 4'h0;
      p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_oe = oe_n; p_dq = dq_oe;
    end
  end

  task automatic do_req(input bit w, input int row, input int col, input logic [3:0] d);
    int key;
    @(negedge clk);
    req_valid = 1; req_write = w; req_row = ROW_W'(row); req_col = COL_W'(col); req_wdata = d;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    chk(cbr_cnt >= N_WAKE, "R2 no request before wake-up", cbr_cnt, N_WAKE);
    key = (row << COL_W) | col;
    if (w) ref_mem[key] = d;
    else begin
      expq.push_back(ref_mem.exists(key) ? ref_mem[key] : dflt(key));
      reads_acc++;
    end
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int unsigned seed;
    int n0, prow;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n && oe_n && !dq_oe && !req_ready && !rd_valid,
        "R1 reset state", {ras_n, cas_n, we_n, oe_n, dq_oe, req_ready}, 6'b111100);
    rst_n = 1;
    @(negedge clk);
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    chk(cbr_cnt >= N_WAKE, "R2 ready after wake-up", cbr_cnt, N_WAKE);

    n0 = nras;
    do_req(1, 5, 3, 4'hA);
    do_req(1, 5, 4, 4'h6);
    do_req(0, 5, 3, 4'h0);
    idle(20);
    chk(nras - n0 == 1, "R6 same-row burst keeps row open", nras - n0, 1);
    n0 = nras;
    do_req(0, 5, 4, 4'h0);
    do_req(0, 9, 4, 4'h0);
    idle(20);
    chk(nras - n0 == 2, "R7 row change reopens", nras - n0, 2);
    n0 = nras;
    do_req(0, 9, 7, 4'h0);
    idle(30);
    do_req(1, 9, 7, 4'h3);
    idle(20);
    chk(nras - n0 == 2, "R7 late request reopens", nras - n0, 2);

    prow = 0;
    for (int i = 0; i < 600; i++) begin
      int row, col, g;
      row = ($urandom_range(0, 9) < 6) ? prow : int'($urandom_range(0, 3));
      col = int'($urandom_range(0, 15));
      do_req($urandom_range(0, 1) == 1, row, col, 4'($urandom_range(0, 15)));
      prow = row;
      g = int'($urandom_range(0, 9));
      if (g > 6) idle(int'($urandom_range(1, 20)));
    end
    idle(3 * T_REF_INT + 100);
    chk(expq.size() == 0 && reads_ret == reads_acc, "R12 every read answered", reads_ret, reads_acc);
    chk(cbr_cnt > N_WAKE + 3, "R11 refreshes continue", cbr_cnt, N_WAKE + 4);
    finish_run();
  end
endmodule